// File: doc/BRIEF.md
# Secure-target interrupt register access filter

This block holds the per-interrupt control storage of an interrupt controller that has a secure and a non-secure state: enable, pending, active and 8-bit priority for each interrupt. It also holds a target-state bit for each interrupt, and every register access from the bus passes through a filter driven by that bit. A non-secure access cannot observe or alter any field that belongs to an interrupt claimed by the secure state. The filter works on single bits and single byte lanes, so one word access can touch visible interrupts and leave hidden ones alone.

Two 4 KiB windows are decoded. The main window at 0xE000E000 is accessed with the security of the bus transfer. The alias window at 0xE002E000 lets secure software see the register space exactly as the non-secure state sees it. The bus is a simple single-cycle 32-bit register port. A read returns its data on the following cycle.

The register offsets within a window are: set-enable 0x100, clear-enable 0x180, set-pending 0x200, clear-pending 0x280, active 0x300, target-state 0x380, each with one bit per interrupt and 32 interrupts per word (word w at offset +4w, bit b = interrupt 32w+b). Priority starts at 0x400 with four interrupts per word: byte lane j of word p is interrupt 4p+j. `NUM_IRQ` must be a power of two of at least 64.

Top module: `irq_sec_filter`

## Requirements
- R1: After reset every target-state bit is 0 (secure), and all enable, pending, active and priority storage is 0. Read data is 0.
- R2: Writing a 1 to a bit of a set-enable word sets that enable bit, and writing a 1 to a clear-enable word clears it. Zero bits have no effect. Both offsets read back the current enable bits.
- R3: Set-pending and clear-pending words behave the same way on the pending bits.
- R4: An active word is written directly and reads back what was written. A priority word is written directly, with byte lane j holding the priority of interrupt 4p+j.
- R5: A target-state bit of 1 makes its interrupt non-secure, and 0 makes it secure. Target-state words are read and written only by secure accesses to the main window. Any other access to them reads 0 and leaves them unchanged.
- R6: For a non-secure access, every enable, pending and active bit, and every priority byte lane, of a secure-targeted interrupt reads as 0 and ignores writes. Fields of non-secure interrupts in the same word are accessed normally.
- R7: A secure access to the alias window (address minus 0x20000) behaves exactly like a non-secure access to the same offset in the main window.
- R8: A non-secure access to the alias window reads 0 and writes nothing. So does any access outside both windows, to an unmapped offset, or to a word beyond `NUM_IRQ`.
- R9: Read data appears on the cycle after the read strobe. It is 0 on the cycle after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_secure | input | 1 | Security attribute of the transfer, 1 for secure |
| bus_addr | input | 32 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |

## Verification
Two functions meet in the same cycle: the per-interrupt visibility mask and the register operation itself. Both act in a single word access whose bits or byte lanes belong partly to secure and partly to non-secure interrupts. The bench provokes this by programming a target word with a boundary inside an enable word and inside a priority word. It then issues non-secure reads, set writes and clear writes through both the main window and the secure alias. Each outcome is judged by a later secure read of the full word: hidden bits must keep their old values while visible bits follow the operation.

// File: rtl/irq_sec_filter.sv
module irq_sec_filter #(
  parameter int NUM_IRQ = 64,
  parameter bit SEC_EXT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_secure,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int NW  = NUM_IRQ / 32;
  localparam int NP  = NUM_IRQ / 4;
  localparam int WIW = $clog2(NW);
  localparam int PIW = $clog2(NP);

  logic [NUM_IRQ-1:0]   en, pend, act, tgt;
  logic [NUM_IRQ*8-1:0] prio;

  logic [11:0] off;
  logic [4:0]  grp;
  logic        in_main, in_alias, ok, eff_s, vis_all, b_ok, p_ok;
  logic [WIW-1:0] widx;
  logic [PIW-1:0] pidx;
  logic [31:0] tw, vm, pm, ew, pw, aw, prw, wm, pwm, rd_val;

  assign off      = bus_addr[11:0];
  assign grp      = off[11:7];
  assign in_main  = bus_addr[31:12] == 20'hE000E;
  assign in_alias = bus_addr[31:12] == 20'hE002E;
  assign ok       = bus_sel && (in_main || (SEC_EXT && in_alias && bus_secure));
  assign eff_s    = SEC_EXT && in_main && bus_secure;
  assign vis_all  = !SEC_EXT || eff_s;
  assign b_ok     = ok && grp >= 5'd2 && grp <= 5'd7 && {27'd0, off[6:2]} < NW;
  assign p_ok     = ok && off[11:10] == 2'b01 && {24'd0, off[9:2]} < NP;
  assign widx     = off[2 +: WIW];
  assign pidx     = off[2 +: PIW];

  assign tw  = tgt[{widx, 5'd0} +: 32];
  assign vm  = {32{vis_all}} | tw;
  assign ew  = en[{widx, 5'd0} +: 32];
  assign pw  = pend[{widx, 5'd0} +: 32];
  assign aw  = act[{widx, 5'd0} +: 32];
  assign prw = prio[{pidx, 5'd0} +: 32];
  assign wm  = bus_wdata & vm;
  assign pwm = bus_wdata & pm;

  for (genvar j = 0; j < 4; j++) begin : g_lane
    assign pm[8*j +: 8] = {8{vis_all | tgt[{pidx, 2'(j)}]}};
  end

  always_comb begin
    rd_val = '0;
    if (b_ok) begin
      case (grp)
        5'd2, 5'd3: rd_val = ew & vm;
        5'd4, 5'd5: rd_val = pw & vm;
        5'd6:       rd_val = aw & vm;
        default:    rd_val = eff_s ? tw : '0;
      endcase
    end else if (p_ok) begin
      rd_val = prw & pm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      pend      <= '0;
      act       <= '0;
      tgt       <= '0;
      prio      <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr) ? rd_val : '0;
      if (bus_wr && b_ok) begin
        case (grp)
          5'd2:    en[{widx, 5'd0} +: 32]   <= ew | wm;
          5'd3:    en[{widx, 5'd0} +: 32]   <= ew & ~wm;
          5'd4:    pend[{widx, 5'd0} +: 32] <= pw | wm;
          5'd5:    pend[{widx, 5'd0} +: 32] <= pw & ~wm;
          5'd6:    act[{widx, 5'd0} +: 32]  <= (aw & ~vm) | wm;
          default: if (eff_s) tgt[{widx, 5'd0} +: 32] <= bus_wdata;
        endcase
      end
      if (bus_wr && p_ok)
        prio[{pidx, 5'd0} +: 32] <= (prw & ~pm) | pwm;
    end
  end
endmodule

// File: rtl/irq_sec_filter_chk.sv
module irq_sec_filter_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               bus_secure,
  input logic [31:0]        bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [NUM_IRQ-1:0] tgt,
  input logic [NUM_IRQ-1:0] en
);
  logic alias_hit, tgt_reg;
  assign alias_hit = bus_addr[31:12] == 20'hE002E;
  assign tgt_reg   = bus_addr[11:7] == 5'd7;

  a_r8_alias_ns_raz: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && alias_hit && !bus_secure) |-> bus_rdata == '0);

  a_r5_tgt_ns_raz: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && tgt_reg && (!bus_secure || alias_hit)) |-> bus_rdata == '0);

  a_r5_tgt_ns_wi: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (!bus_secure || alias_hit)) |=> $stable(tgt));

  a_r6_en_hidden_wi: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && bus_wr && (!bus_secure || alias_hit)) |->
      ((en ^ $past(en)) & ~$past(tgt)) == '0);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_sel || bus_wr) |-> bus_rdata == '0);
endmodule

bind irq_sec_filter irq_sec_filter_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tgt(tgt), .en(en)
);

// File: tb/sim_irq_sec_filter.sv
`timescale 1ns/1ps
module sim_irq_sec_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0, errors = 0;
  logic [31:0] r;

  localparam logic [31:0] M = 32'hE000E000, A = 32'hE002E000;

  irq_sec_filter u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_secure = s; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic s, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_secure = s; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    rd(M + 32'h380, 1'b1, r); chk("R1 target reset", r, 32'h0);
    rd(M + 32'h104, 1'b1, r); chk("R1 enable reset", r, 32'h0);
    rd(M + 32'h400, 1'b1, r); chk("R1 priority reset", r, 32'h0);
  endtask

  task automatic t_enable;
    wr(M + 32'h100, 32'hF0F0_00F1, 1'b1);
    rd(M + 32'h100, 1'b1, r); chk("R2 set-enable", r, 32'hF0F0_00F1);
    wr(M + 32'h180, 32'h0000_0001, 1'b1);
    rd(M + 32'h180, 1'b1, r); chk("R2 clear-enable", r, 32'hF0F0_00F0);
  endtask

  task automatic t_pend;
    wr(M + 32'h204, 32'h8000_0003, 1'b1);
    wr(M + 32'h284, 32'h0000_0003, 1'b1);
    rd(M + 32'h204, 1'b1, r); chk("R3 pending set/clear", r, 32'h8000_0000);
  endtask

  task automatic t_act_prio;
    wr(M + 32'h300, 32'h1234_5678, 1'b1);
    rd(M + 32'h300, 1'b1, r); chk("R4 active", r, 32'h1234_5678);
    wr(M + 32'h404, 32'hA1B2_C3D4, 1'b1);
    rd(M + 32'h404, 1'b1, r); chk("R4 priority", r, 32'hA1B2_C3D4);
  endtask

  task automatic t_target;
    wr(M + 32'h380, 32'h0000_3FFF, 1'b1);
    rd(M + 32'h380, 1'b1, r); chk("R5 target secure rw", r, 32'h0000_3FFF);
    rd(M + 32'h380, 1'b0, r); chk("R5 target ns read", r, 32'h0);
    wr(M + 32'h380, 32'hFFFF_FFFF, 1'b0);
    rd(M + 32'h380, 1'b1, r); chk("R5 target ns write", r, 32'h0000_3FFF);
  endtask

  task automatic t_mask;
    rd(M + 32'h100, 1'b0, r); chk("R6 ns enable read", r, 32'h0000_00F0);
    wr(M + 32'h100, 32'h0F0F_0F0F, 1'b0);
    rd(M + 32'h100, 1'b1, r); chk("R6 ns set-enable", r, 32'hF0F0_0FFF);
    wr(M + 32'h180, 32'hFFFF_FFFF, 1'b0);
    rd(M + 32'h100, 1'b1, r); chk("R6 ns clear-enable", r, 32'hF0F0_0000);
    rd(M + 32'h300, 1'b0, r); chk("R6 ns active read", r, 32'h0000_1678);
    wr(M + 32'h40C, 32'h1122_3344, 1'b1);
    rd(M + 32'h40C, 1'b0, r); chk("R6 ns priority lanes", r, 32'h0000_3344);
    wr(M + 32'h40C, 32'hAAAA_AAAA, 1'b0);
    rd(M + 32'h40C, 1'b1, r); chk("R6 ns priority write", r, 32'h1122_AAAA);
    rd(M + 32'h410, 1'b0, r); chk("R6 ns hidden priority", r, 32'h0);
  endtask

  task automatic t_alias;
    rd(A + 32'h100, 1'b1, r); chk("R7 alias secure read", r, 32'h0);
    wr(A + 32'h100, 32'h8000_0005, 1'b1);
    rd(M + 32'h100, 1'b1, r); chk("R7 alias secure write", r, 32'hF0F0_0005);
    rd(A + 32'h40C, 1'b1, r); chk("R7 alias priority", r, 32'h0000_AAAA);
    rd(A + 32'h380, 1'b1, r); chk("R7 alias target read", r, 32'h0);
    rd(A + 32'h100, 1'b0, r); chk("R8 alias ns read", r, 32'h0);
    wr(A + 32'h100, 32'hFFFF_FFFF, 1'b0);
    rd(M + 32'h100, 1'b1, r); chk("R8 alias ns write", r, 32'hF0F0_0005);
  endtask

  task automatic t_unmapped;
    wr(M + 32'h108, 32'hFFFF_FFFF, 1'b1);
    rd(M + 32'h108, 1'b1, r); chk("R8 word beyond range", r, 32'h0);
    rd(32'hE000_F100, 1'b1, r); chk("R8 outside windows", r, 32'h0);
    rd(M + 32'h000, 1'b1, r); chk("R8 unmapped offset", r, 32'h0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_secure = 1'b1; bus_addr = M + 32'h300;
    @(negedge clk);
    chk("R9 data next cycle", bus_rdata, 32'h1234_5678);
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R9 zero after idle", bus_rdata, 32'h0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_pend();
    t_act_prio();
    t_target();
    t_mask();
    t_alias();
    t_unmapped();
    t_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule